// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block sits beside the protocol engine of a CAN controller and decides how much the node is still trusted on the bus. It keeps two error counters, one for transmission and one for reception. Each counter moves on single-cycle event strobes from the engine. Failed transmissions are weighted eight times as heavily as anything else. From the two counts the block derives one of three node states:

- error-active: full participation.
- error-passive: errors may only be flagged with recessive error frames.
- bus-off: the node must not drive the bus at all.

The engine reads the state flags to choose the error-frame type, and reads the bus-off flag to release the bus. Once a node is in bus-off, its counters are frozen. The only way back is a recovery sequence: the engine reports runs of 11 consecutive recessive bits, and after a fixed number of such runs both counters are cleared and the node is error-active again.

Top module: `errconf_tracker`

## Requirements
- R1: After synchronous reset both counters read 0, the node is error-active, and the active-error-frame flag is 1.
- R2: Outside bus-off, a transmit-error strobe adds 8 to the transmit counter. The new value is visible in the cycle after the strobe.
- R3: Outside bus-off, a receive-error strobe adds 1 to the receive counter. The receive counter saturates at 255.
- R4: Outside bus-off, a successful-transmit strobe subtracts 1 from the transmit counter and a successful-receive strobe subtracts 1 from the receive counter. Neither counter goes below 0.
- R5: When an error strobe and a success strobe for the same direction arrive in the same cycle, only the error is counted.
- R6: The node is error-passive when either counter is at least 128 and the transmit counter is below 256. It is error-active when both counters are below 128. The state flags change in the same cycle as the counter that crosses the threshold.
- R7: The transmit counter holds at 256 once it gets there. At 256 the node is bus-off: bus-off flag 1, error-active and error-passive flags 0. Thirty-two transmit errors from zero reach this state.
- R8: While the node is bus-off, the error and success strobes of both directions have no effect on either counter.
- R9: A bus-off node returns to error-active with both counters cleared in the cycle after its 128th recessive-run strobe. After 127 strobes it is still bus-off.
- R10: Recessive-run strobes seen before the node enters bus-off do not count toward recovery.
- R11: The active-error-frame flag is 1 exactly while the node is error-active.
- R12: The receive counter alone never puts the node in bus-off, however many receive errors occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Strobe: transmit error detected |
| rx_err_i | input | 1 | Strobe: receive error detected |
| tx_ok_i | input | 1 | Strobe: frame transmitted successfully |
| rx_ok_i | input | 1 | Strobe: frame received successfully |
| idle11_i | input | 1 | Strobe: 11 consecutive recessive bits observed |
| tec_o | output | CNT_W (9) | Transmit error counter |
| rec_o | output | CNT_W (9) | Receive error counter |
| err_active_o | output | 1 | Node is error-active |
| err_passive_o | output | 1 | Node is error-passive |
| bus_off_o | output | 1 | Node is bus-off and must not drive the bus |
| active_flag_o | output | 1 | 1: send active error frames; 0: recessive only |

## Verification
The bench builds the tracker with its default parameters: a weight of 8 per transmit error, a passive threshold of 128, a bus-off level of 256, a receive cap of 255 and a recovery length of 128 recessive runs. With these values every threshold can be reached within a few hundred strobes. This covers the exact 15th/16th and 31st/32nd transmit-error boundaries, saturation of the receive counter well past 128, and the 127th versus 128th recovery run, all inside a short directed run.

// File: rtl/errconf_pkg.sv
package errconf_pkg;

    typedef enum logic [1:0] {
        NODE_ACTIVE  = 2'd0,
        NODE_PASSIVE = 2'd1,
        NODE_BUSOFF  = 2'd2
    } node_state_e;

    localparam int unsigned DEF_CNT_W       = 9;
    localparam int unsigned DEF_TX_WEIGHT   = 8;
    localparam int unsigned DEF_RX_WEIGHT   = 1;
    localparam int unsigned DEF_PASSIVE_LVL = 128;
    localparam int unsigned DEF_BUSOFF_LVL  = 256;
    localparam int unsigned DEF_RX_CAP      = 255;
    localparam int unsigned DEF_RECOVER_RUN = 128;

    // Classify a pair of counter values into the node state.
    function automatic node_state_e classify(
        input int unsigned tec,
        input int unsigned rec,
        input int unsigned passive_lvl,
        input int unsigned busoff_lvl
    );
        if (tec >= busoff_lvl)
            return NODE_BUSOFF;
        else if (tec >= passive_lvl || rec >= passive_lvl)
            return NODE_PASSIVE;
        else
            return NODE_ACTIVE;
    endfunction

endpackage

// File: rtl/errconf_tx_counter.sv
module errconf_tx_counter #(
    parameter int unsigned CNT_W  = 9,
    parameter int unsigned WEIGHT = 8,
    parameter int unsigned LIMIT  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frozen,
    input  logic             clear,
    input  logic             err,
    input  logic             ok,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W:0]   LIMIT_W  = (CNT_W+1)'(LIMIT);
    localparam logic [CNT_W:0]   WEIGHT_W = (CNT_W+1)'(WEIGHT);

    logic [CNT_W:0] sum;

    always_comb begin
        sum      = {1'b0, cnt_q} + WEIGHT_W;
        cnt_next = cnt_q;
        if (clear)
            cnt_next = '0;
        else if (frozen)
            cnt_next = cnt_q;
        else if (err)
            cnt_next = (sum >= LIMIT_W) ? LIMIT_W[CNT_W-1:0] : sum[CNT_W-1:0];
        else if (ok && cnt_q != '0)
            cnt_next = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

    AST_TEC_BOUND: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt_q} <= LIMIT_W); // R7

    AST_TEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (err && !frozen && !clear && ({1'b0, cnt_q} + WEIGHT_W <= LIMIT_W))
        |=> ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + WEIGHT_W)); // R2

    AST_TEC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frozen && !clear) |=> $stable(cnt_q)); // R8

    AST_TEC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ok && !err && !frozen && !clear && cnt_q == '0) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/errconf_rx_counter.sv
module errconf_rx_counter #(
    parameter int unsigned CNT_W  = 9,
    parameter int unsigned WEIGHT = 1,
    parameter int unsigned CAP    = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frozen,
    input  logic             clear,
    input  logic             err,
    input  logic             ok,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W:0] CAP_W    = (CNT_W+1)'(CAP);
    localparam logic [CNT_W:0] WEIGHT_W = (CNT_W+1)'(WEIGHT);

    logic [CNT_W:0] sum;

    always_comb begin
        sum      = {1'b0, cnt_q} + WEIGHT_W;
        cnt_next = cnt_q;
        if (clear)
            cnt_next = '0;
        else if (frozen)
            cnt_next = cnt_q;
        else if (err)
            cnt_next = (sum >= CAP_W) ? CAP_W[CNT_W-1:0] : sum[CNT_W-1:0];
        else if (ok && cnt_q != '0)
            cnt_next = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

    AST_REC_CAP: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt_q} <= CAP_W); // R3

    AST_REC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ok && !err && !frozen && !clear && cnt_q == '0) |=> (cnt_q == '0)); // R4

    AST_REC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frozen && !clear) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/errconf_recovery.sv
module errconf_recovery #(
    parameter int unsigned RUNS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic in_busoff,
    input  logic idle11,
    output logic done
);
    localparam int unsigned RW = $clog2(RUNS + 1);
    localparam logic [RW-1:0] LAST = RW'(RUNS - 1);

    logic [RW-1:0] runs_q;

    assign done = in_busoff && idle11 && (runs_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !in_busoff)
            runs_q <= '0;
        else if (idle11)
            runs_q <= (runs_q == LAST) ? '0 : runs_q + 1'b1;
    end

    AST_RUNS_BOUND: assert property (@(posedge clk) disable iff (rst)
        runs_q <= LAST); // R9

    AST_RUNS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (in_busoff && !idle11) |=> $stable(runs_q)); // R9

endmodule

// File: rtl/errconf_state.sv
module errconf_state
    import errconf_pkg::*;
#(
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned PASSIVE_LVL = 128,
    parameter int unsigned BUSOFF_LVL  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] tec_next,
    input  logic [CNT_W-1:0] rec_next,
    input  logic [CNT_W-1:0] tec_q,
    input  logic [CNT_W-1:0] rec_q,
    output node_state_e      state_q,
    output logic             err_active_o,
    output logic             err_passive_o,
    output logic             bus_off_o,
    output logic             active_flag_o
);
    node_state_e state_next;

    always_comb begin
        if (clear)
            state_next = NODE_ACTIVE;
        else
            state_next = classify(32'(tec_next), 32'(rec_next),
                                  PASSIVE_LVL, BUSOFF_LVL);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= NODE_ACTIVE;
        else
            state_q <= state_next;
    end

    assign err_active_o  = (state_q == NODE_ACTIVE);
    assign err_passive_o = (state_q == NODE_PASSIVE);
    assign bus_off_o     = (state_q == NODE_BUSOFF);
    assign active_flag_o = (state_q == NODE_ACTIVE);

    AST_ACTIVE_BAND: assert property (@(posedge clk) disable iff (rst)
        err_active_o |-> (32'(tec_q) < PASSIVE_LVL && 32'(rec_q) < PASSIVE_LVL)); // R6

    AST_PASSIVE_BAND: assert property (@(posedge clk) disable iff (rst)
        err_passive_o |-> ((32'(tec_q) >= PASSIVE_LVL || 32'(rec_q) >= PASSIVE_LVL)
                           && 32'(tec_q) < BUSOFF_LVL)); // R6

    AST_BUSOFF_LEVEL: assert property (@(posedge clk) disable iff (rst)
        bus_off_o |-> (32'(tec_q) == BUSOFF_LVL)); // R7

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
        $onehot({err_active_o, err_passive_o, bus_off_o})); // R6

endmodule

// File: rtl/errconf_tracker.sv
module errconf_tracker
    import errconf_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned TX_WEIGHT   = DEF_TX_WEIGHT,
    parameter int unsigned RX_WEIGHT   = DEF_RX_WEIGHT,
    parameter int unsigned PASSIVE_LVL = DEF_PASSIVE_LVL,
    parameter int unsigned BUSOFF_LVL  = DEF_BUSOFF_LVL,
    parameter int unsigned RX_CAP      = DEF_RX_CAP,
    parameter int unsigned RECOVER_RUN = DEF_RECOVER_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             idle11_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             err_active_o,
    output logic             err_passive_o,
    output logic             bus_off_o,
    output logic             active_flag_o
);
    logic [CNT_W-1:0] tec_next, rec_next;
    logic             recover;
    node_state_e      state_q;

    errconf_recovery #(.RUNS(RECOVER_RUN)) u_recovery (
        .clk       (clk),
        .rst       (rst),
        .in_busoff (bus_off_o),
        .idle11    (idle11_i),
        .done      (recover)
    );

    errconf_tx_counter #(
        .CNT_W (CNT_W), .WEIGHT (TX_WEIGHT), .LIMIT (BUSOFF_LVL)
    ) u_tec (
        .clk      (clk),
        .rst      (rst),
        .frozen   (bus_off_o),
        .clear    (recover),
        .err      (tx_err_i),
        .ok       (tx_ok_i),
        .cnt_next (tec_next),
        .cnt_q    (tec_o)
    );

    errconf_rx_counter #(
        .CNT_W (CNT_W), .WEIGHT (RX_WEIGHT), .CAP (RX_CAP)
    ) u_rec (
        .clk      (clk),
        .rst      (rst),
        .frozen   (bus_off_o),
        .clear    (recover),
        .err      (rx_err_i),
        .ok       (rx_ok_i),
        .cnt_next (rec_next),
        .cnt_q    (rec_o)
    );

    errconf_state #(
        .CNT_W (CNT_W), .PASSIVE_LVL (PASSIVE_LVL), .BUSOFF_LVL (BUSOFF_LVL)
    ) u_state (
        .clk           (clk),
        .rst           (rst),
        .clear         (recover),
        .tec_next      (tec_next),
        .rec_next      (rec_next),
        .tec_q         (tec_o),
        .rec_q         (rec_o),
        .state_q       (state_q),
        .err_active_o  (err_active_o),
        .err_passive_o (err_passive_o),
        .bus_off_o     (bus_off_o),
        .active_flag_o (active_flag_o)
    );

    AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_off_o) |-> (tec_o == '0 && rec_o == '0 && state_q == NODE_ACTIVE)); // R9

    AST_REC_NO_BUSOFF: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_off_o) |-> (32'(tec_o) == BUSOFF_LVL)); // R12

endmodule

// File: tb/errconf_tracker_test.sv
module errconf_tracker_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, idle11 = 0;
    logic [8:0] tec, rec;
    logic act, pas, boff, aflag;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    errconf_tracker uut (
        .clk (clk), .rst (rst),
        .tx_err_i (tx_err), .rx_err_i (rx_err), .tx_ok_i (tx_ok),
        .rx_ok_i (rx_ok), .idle11_i (idle11),
        .tec_o (tec), .rec_o (rec),
        .err_active_o (act), .err_passive_o (pas), .bus_off_o (boff),
        .active_flag_o (aflag)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // state code: 0 active, 1 passive, 2 bus-off
    task automatic chk_state(input string req, input int exp_code);
        chk({req, " active"},  int'(act),   int'(exp_code == 0));
        chk({req, " passive"}, int'(pas),   int'(exp_code == 1));
        chk({req, " busoff"},  int'(boff),  int'(exp_code == 2));
        chk({req, " flag"},    int'(aflag), int'(exp_code == 0));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    // m = {idle11, rx_ok, tx_ok, rx_err, tx_err}; result sampled at next negedge
    task automatic pulse(input logic [4:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            tx_err = m[0]; rx_err = m[1]; tx_ok = m[2]; rx_ok = m[3]; idle11 = m[4];
            @(negedge clk);
            {tx_err, rx_err, tx_ok, rx_ok, idle11} = '0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tec", int'(tec), 0);
        chk("R1 rec", int'(rec), 0);
        chk_state("R1/R11 reset", 0);
    endtask

    task automatic t_steps();
        do_reset();
        pulse(5'b00001, 1);
        chk("R2 tec one step", int'(tec), 8);
        pulse(5'b00001, 2);
        chk("R2 tec three steps", int'(tec), 24);
        pulse(5'b00100, 1);
        chk("R4 tec minus one", int'(tec), 23);
        pulse(5'b00010, 5);
        chk("R3 rec plus five", int'(rec), 5);
        pulse(5'b01000, 6);
        chk("R4 rec floor", int'(rec), 0);
        pulse(5'b00100, 30);
        chk("R4 tec floor", int'(tec), 0);
    endtask

    task automatic t_simul();
        do_reset();
        pulse(5'b00101, 1);
        chk("R5 tx err wins", int'(tec), 8);
        pulse(5'b01010, 1);
        chk("R5 rx err wins", int'(rec), 1);
    endtask

    task automatic t_passive();
        do_reset();
        pulse(5'b00001, 15);
        chk("R6 tec 120", int'(tec), 120);
        chk_state("R6 still active", 0);
        pulse(5'b00001, 1);
        chk("R6 tec 128", int'(tec), 128);
        chk_state("R6/R11 passive", 1);
        pulse(5'b00100, 1);
        chk("R6 tec 127", int'(tec), 127);
        chk_state("R6 back active", 0);
    endtask

    task automatic t_rx_sat();
        do_reset();
        pulse(5'b00010, 127);
        chk_state("R6 rec 127 active", 0);
        pulse(5'b00010, 1);
        chk("R6 rec 128", int'(rec), 128);
        chk_state("R6 rec passive", 1);
        pulse(5'b00010, 200);
        chk("R3 rec saturates", int'(rec), 255);
        chk_state("R12 no busoff from rec", 1);
    endtask

    task automatic t_busoff_recover();
        do_reset();
        pulse(5'b00001, 31);
        chk("R7 tec 248", int'(tec), 248);
        chk_state("R7 passive at 248", 1);
        pulse(5'b00001, 1);
        chk("R7 tec 256", int'(tec), 256);
        chk_state("R7 busoff", 2);
        pulse(5'b00001, 1);
        chk("R7 tec holds", int'(tec), 256);
        pulse(5'b00110, 3);
        pulse(5'b01010, 3);
        chk("R8 tec frozen", int'(tec), 256);
        chk("R8 rec frozen", int'(rec), 0);
        chk_state("R8 still busoff", 2);
        pulse(5'b10000, 127);
        chk_state("R9 127 runs", 2);
        pulse(5'b10000, 1);
        chk("R9 tec cleared", int'(tec), 0);
        chk("R9 rec cleared", int'(rec), 0);
        chk_state("R9 recovered", 0);
    endtask

    task automatic t_early_idle();
        do_reset();
        pulse(5'b10000, 20);
        pulse(5'b00001, 32);
        chk_state("R10 busoff", 2);
        pulse(5'b10000, 127);
        chk_state("R10 early runs ignored", 2);
        pulse(5'b10000, 1);
        chk_state("R10 recovered on 128th", 0);
    endtask

    initial begin
        t_reset();
        t_steps();
        t_simul();
        t_passive();
        t_rx_sat();
        t_busoff_recover();
        t_early_idle();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule